// File: doc/BRIEF.md
# Field-Gated Trigger Pulse Generator

This block produces one programmable trigger waveform for an image-sensor timing generator. It does not count anything itself. It watches a line counter, a pixel counter and a mode field counter, together with a field-start strobe, all supplied from outside. Within one chosen field of the mode cycle, the output leaves its idle level at a programmed line/pixel point. It comes back to the idle level at a second programmed point.

Software programs the block through a simple write port with five registers: idle level, first toggle point, second toggle point, field choice with enable, and sync-pin direction. All of them are held in shadow copies and go live together on the field-start strobe, so a field never sees a half-updated setting. The waveform can drive a shared sync pad. The pad can instead be released so that it acts as an external sync input, which is passed through to the rest of the chip.

Top module: `field_pulse_gen`

## Requirements
- R1: With the enable set and the output outside its active window, `pulse_o` equals the idle level held in bit 0 of register address 0.
- R2: Toggle-point words (address 1 for the first point, address 2 for the second) carry the line in bits [11:0] and the pixel in bits [25:13]. Bit 12 is ignored.
- R3: The first toggle inverts the output only when the enable is set and `field_cnt` equals bits [2:0] of address 3. No toggle happens in any other field.
- R4: While bit 3 of address 3 (the enable) is 0 in the live settings, `pulse_o` stays at the idle level.
- R5: When bit 0 of address 4 is 0, `sync_oe_o` is 1 and `sync_o` equals `pulse_o`, while `sync_ext_o` is 0. When that bit is 1, `sync_oe_o` is 0 and `sync_ext_o` follows `sync_i`.
- R6: After reset, all settings are zero: the output is at level 0, the block is disabled and the pad is driven.
- R7: After the first toggle, a match on the second toggle point returns the output to the idle level for the rest of the field.
- R8: If the second point is not later than the first in (line, pixel) order, only the first toggle acts in that field.
- R9: On every field-start cycle the output returns to the idle level. This holds even when the second toggle was never reached.
- R10: Writes change only shadow copies. These become live on the clock edge that samples `field_start` high.
- R11: The output changes on the clock edge that samples the counters equal to a toggle point, so it is one clock behind the match. A match in a field-start cycle is not acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| line_cnt | input | LINE_W | Current line number in the field |
| pix_cnt | input | PIX_W | Current pixel number in the line |
| field_cnt | input | FLD_W | Mode field counter value |
| field_start | input | 1 | One-cycle strobe at the first pixel of each field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 idle level, 1 first point, 2 second point, 3 field/enable, 4 pad direction) |
| wr_data | input | LINE_W+1+PIX_W | Register write data |
| sync_i | input | 1 | Value read from the sync pad |
| pulse_o | output | 1 | Generated trigger waveform |
| sync_o | output | 1 | Value to drive onto the sync pad |
| sync_oe_o | output | 1 | Pad output enable, 1 = drive |
| sync_ext_o | output | 1 | External sync seen on the pad when it is released, else 0 |

## Verification
The bench builds the block with its default widths: 12-bit line, 13-bit pixel and 3-bit field counters. It drives a short field of 6 lines by 10 pixels with the field counter cycling 0, 1, 2. Because the field count never reaches 7, a field select of 7 can be shown to never fire. A second point on line 9 is never reached, which exercises the field-start restore. The full-width word still lets junk in bit 12 show that the layout is honoured. The short field also puts many field boundaries, mid-field writes and a toggle point on the field-start pixel within a small number of cycles.

// File: rtl/fpg_pkg.sv
`timescale 1ns/1ps
package fpg_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_IDLE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ON   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_OFF  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FSEL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PAD  = 3'd4;

  // progress of the waveform within one field
  typedef enum logic [1:0] {
    PH_WAIT   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_DONE   = 2'd2
  } phase_e;
endpackage

// File: rtl/fpg_match.sv
`timescale 1ns/1ps
// Equality of the running counters with one programmed toggle point.
module fpg_match #(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 13
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] pos_ln,
  input  logic [PIX_W-1:0]  pos_px,
  output logic              hit_o
);
  logic line_eq;
  logic pix_eq;

  always_comb begin
    line_eq = (line_cnt == pos_ln);
    pix_eq  = (pix_cnt == pos_px);
    hit_o   = line_eq & pix_eq;
  end
endmodule

// File: rtl/fpg_order.sv
`timescale 1ns/1ps
// Reports whether the second point lies strictly after the first in raster order.
module fpg_order #(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 13
) (
  input  logic [LINE_W-1:0] first_ln,
  input  logic [PIX_W-1:0]  first_px,
  input  logic [LINE_W-1:0] second_ln,
  input  logic [PIX_W-1:0]  second_px,
  output logic              later_o
);
  logic line_gt;
  logic line_eq;
  logic pix_gt;

  always_comb begin
    line_gt = (second_ln > first_ln);
    line_eq = (second_ln == first_ln);
    pix_gt  = (second_px > first_px);
    later_o = line_gt | (line_eq & pix_gt);
  end
endmodule

// File: rtl/fpg_regs.sv
`timescale 1ns/1ps
// Shadow register bank written by the host and live copy loaded at field start.
module fpg_regs #(
  parameter  int LINE_W = 12,
  parameter  int PIX_W  = 13,
  parameter  int FLD_W  = 3,
  localparam int WORD_W = LINE_W + 1 + PIX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [fpg_pkg::ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         field_start,
  output logic                         shd_pol,
  output logic                         act_pol,
  output logic [1:0][LINE_W-1:0]       act_ln,
  output logic [1:0][PIX_W-1:0]        act_px,
  output logic [FLD_W-1:0]             act_sel,
  output logic                         act_en,
  output logic                         act_in_mode
);
  import fpg_pkg::*;

  localparam int PX_LSB = LINE_W + 1;

  logic                   sh_pol_q,  sh_pol_d;
  logic [1:0][LINE_W-1:0] sh_ln_q,   sh_ln_d;
  logic [1:0][PIX_W-1:0]  sh_px_q,   sh_px_d;
  logic [FLD_W-1:0]       sh_sel_q,  sh_sel_d;
  logic                   sh_en_q,   sh_en_d;
  logic                   sh_mode_q, sh_mode_d;

  logic wr_idle;
  logic wr_fsel;
  logic wr_pad;

  assign wr_idle = wr_en & (wr_addr == ADDR_IDLE);
  assign wr_fsel = wr_en & (wr_addr == ADDR_FSEL);
  assign wr_pad  = wr_en & (wr_addr == ADDR_PAD);

  // one decoder per toggle point
  for (genvar t = 0; t < 2; t++) begin : g_pos
    logic wr_pos;
    assign wr_pos     = wr_en & (wr_addr == (ADDR_ON + ADDR_W'(t)));
    assign sh_ln_d[t] = wr_pos ? wr_data[LINE_W-1:0]      : sh_ln_q[t];
    assign sh_px_d[t] = wr_pos ? wr_data[PX_LSB +: PIX_W] : sh_px_q[t];
  end

  always_comb begin
    sh_pol_d  = wr_idle ? wr_data[0]       : sh_pol_q;
    sh_sel_d  = wr_fsel ? wr_data[FLD_W-1:0] : sh_sel_q;
    sh_en_d   = wr_fsel ? wr_data[FLD_W]   : sh_en_q;
    sh_mode_d = wr_pad  ? wr_data[0]       : sh_mode_q;
  end

  // shadow bank, clock enable = write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pol_q  <= 1'b0;
      sh_ln_q   <= '0;
      sh_px_q   <= '0;
      sh_sel_q  <= '0;
      sh_en_q   <= 1'b0;
      sh_mode_q <= 1'b0;
    end else if (wr_en) begin
      sh_pol_q  <= sh_pol_d;
      sh_ln_q   <= sh_ln_d;
      sh_px_q   <= sh_px_d;
      sh_sel_q  <= sh_sel_d;
      sh_en_q   <= sh_en_d;
      sh_mode_q <= sh_mode_d;
    end
  end

  // live bank, clock enable = field start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pol     <= 1'b0;
      act_ln      <= '0;
      act_px      <= '0;
      act_sel     <= '0;
      act_en      <= 1'b0;
      act_in_mode <= 1'b0;
    end else if (field_start) begin
      act_pol     <= sh_pol_q;
      act_ln      <= sh_ln_q;
      act_px      <= sh_px_q;
      act_sel     <= sh_sel_q;
      act_en      <= sh_en_q;
      act_in_mode <= sh_mode_q;
    end
  end

  assign shd_pol = sh_pol_q;

  AST_LIVE_HOLDS_MIDFIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(act_pol) && $stable(act_ln) && $stable(act_px) &&
                      $stable(act_sel) && $stable(act_en) && $stable(act_in_mode)));  // R10
endmodule

// File: rtl/fpg_core.sv
`timescale 1ns/1ps
// Per-field waveform sequencer: idle -> active -> idle, restarted every field.
module fpg_core #(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 13,
  parameter int FLD_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   field_start,
  input  logic [LINE_W-1:0]      line_cnt,
  input  logic [PIX_W-1:0]       pix_cnt,
  input  logic [FLD_W-1:0]       field_cnt,
  input  logic                   shd_pol,
  input  logic                   act_pol,
  input  logic [1:0][LINE_W-1:0] act_ln,
  input  logic [1:0][PIX_W-1:0]  act_px,
  input  logic [FLD_W-1:0]       act_sel,
  input  logic                   act_en,
  output logic                   level_o
);
  import fpg_pkg::*;

  logic [1:0] hit;
  logic       off_after_on;
  logic       armed;
  logic       ce;
  phase_e     phase_q, phase_d;
  logic       level_q, level_d;

  for (genvar t = 0; t < 2; t++) begin : g_cmp
    fpg_match #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_match (
      .line_cnt (line_cnt),
      .pix_cnt  (pix_cnt),
      .pos_ln   (act_ln[t]),
      .pos_px   (act_px[t]),
      .hit_o    (hit[t])
    );
  end

  fpg_order #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_order (
    .first_ln  (act_ln[0]),
    .first_px  (act_px[0]),
    .second_ln (act_ln[1]),
    .second_px (act_px[1]),
    .later_o   (off_after_on)
  );

  assign armed = act_en & (field_cnt == act_sel);
  assign ce    = field_start | (armed & (|hit));

  always_comb begin
    phase_d = phase_q;
    level_d = level_q;
    if (field_start) begin
      // live settings load on this same edge, so take the idle level from the shadow
      phase_d = PH_WAIT;
      level_d = shd_pol;
    end else if (armed) begin
      case (phase_q)
        PH_WAIT: begin
          if (hit[0]) begin
            phase_d = PH_ACTIVE;
            level_d = ~act_pol;
          end
        end
        PH_ACTIVE: begin
          if (hit[1] && off_after_on) begin
            phase_d = PH_DONE;
            level_d = act_pol;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      level_q <= 1'b0;
    end else if (ce) begin
      phase_q <= phase_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  AST_IDLE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (level_q == act_pol));  // R4
  AST_FIELD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> ((level_q == act_pol) && (phase_q == PH_WAIT)));  // R9
  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && armed && (phase_q == PH_WAIT) && hit[0]) |=> (level_q != act_pol));  // R11
  AST_NO_EARLY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && (phase_q == PH_ACTIVE) && !off_after_on) |=> (phase_q == PH_ACTIVE));  // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && (phase_q == PH_DONE)) |=> ((phase_q == PH_DONE) && (level_q == act_pol)));  // R7
  AST_ACTIVE_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE) |-> (level_q != act_pol));  // R3
endmodule

// File: rtl/field_pulse_gen.sv
`timescale 1ns/1ps
// Top: register bank, field sequencer and sync pad steering.
module field_pulse_gen #(
  parameter  int LINE_W = 12,
  parameter  int PIX_W  = 13,
  parameter  int FLD_W  = 3,
  localparam int WORD_W = LINE_W + 1 + PIX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINE_W-1:0]          line_cnt,
  input  logic [PIX_W-1:0]           pix_cnt,
  input  logic [FLD_W-1:0]           field_cnt,
  input  logic                       field_start,
  input  logic                       wr_en,
  input  logic [fpg_pkg::ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       sync_i,
  output logic                       pulse_o,
  output logic                       sync_o,
  output logic                       sync_oe_o,
  output logic                       sync_ext_o
);
  logic                   shd_pol;
  logic                   act_pol;
  logic [1:0][LINE_W-1:0] act_ln;
  logic [1:0][PIX_W-1:0]  act_px;
  logic [FLD_W-1:0]       act_sel;
  logic                   act_en;
  logic                   act_in_mode;
  logic                   level;

  fpg_regs #(.LINE_W(LINE_W), .PIX_W(PIX_W), .FLD_W(FLD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .field_start (field_start),
    .shd_pol     (shd_pol),
    .act_pol     (act_pol),
    .act_ln      (act_ln),
    .act_px      (act_px),
    .act_sel     (act_sel),
    .act_en      (act_en),
    .act_in_mode (act_in_mode)
  );

  fpg_core #(.LINE_W(LINE_W), .PIX_W(PIX_W), .FLD_W(FLD_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .line_cnt    (line_cnt),
    .pix_cnt     (pix_cnt),
    .field_cnt   (field_cnt),
    .shd_pol     (shd_pol),
    .act_pol     (act_pol),
    .act_ln      (act_ln),
    .act_px      (act_px),
    .act_sel     (act_sel),
    .act_en      (act_en),
    .level_o     (level)
  );

  always_comb begin
    pulse_o    = level;
    sync_oe_o  = ~act_in_mode;
    sync_o     = level;
    sync_ext_o = act_in_mode & sync_i;
  end

  AST_PAD_DIR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(sync_oe_o));  // R10
endmodule

// File: tb/tb_field_pulse_gen.sv
`timescale 1ns/1ps
module tb_field_pulse_gen;
  import fpg_pkg::*;

  localparam int LPF = 6;   // lines per field driven by the bench
  localparam int PPL = 10;  // pixels per line driven by the bench
  localparam int FIELD_CYC = LPF * PPL;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ln;
  logic [12:0] px;
  logic [2:0]  fld;
  logic        fs;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [25:0] wr_data;
  logic        sync_i;
  logic        pulse_o, sync_o, sync_oe_o, sync_ext_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R6";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  field_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .line_cnt(ln), .pix_cnt(px), .field_cnt(fld),
    .field_start(fs), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_i(sync_i), .pulse_o(pulse_o), .sync_o(sync_o), .sync_oe_o(sync_oe_o),
    .sync_ext_o(sync_ext_o)
  );

  // raster counters
  always @(negedge clk) begin
    if (!rst_n) begin
      ln <= '0; px <= '0; fld <= '0;
    end else if (px == PPL - 1) begin
      px <= '0;
      if (ln == LPF - 1) begin
        ln  <= '0;
        fld <= (fld == 3'd2) ? 3'd0 : fld + 3'd1;
      end else ln <= ln + 12'd1;
    end else px <= px + 13'd1;
  end
  assign fs = (ln == 12'd0) && (px == 13'd0);

  // behavioural reference
  int s_pol, s_sel, s_en, s_mode;
  int s_ln[2], s_px[2];
  int a_pol, a_sel, a_en, a_mode;
  int a_ln[2], a_px[2];
  int m_lvl, m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pol = 0; s_sel = 0; s_en = 0; s_mode = 0;
      a_pol = 0; a_sel = 0; a_en = 0; a_mode = 0;
      for (int i = 0; i < 2; i++) begin s_ln[i] = 0; s_px[i] = 0; a_ln[i] = 0; a_px[i] = 0; end
      m_lvl = 0; m_ph = 0;
    end else begin
      if (fs) begin
        a_pol = s_pol; a_sel = s_sel; a_en = s_en; a_mode = s_mode;
        for (int i = 0; i < 2; i++) begin a_ln[i] = s_ln[i]; a_px[i] = s_px[i]; end
        m_lvl = s_pol; m_ph = 0;
      end else if (a_en != 0 && int'(fld) == a_sel) begin
        if (m_ph == 0 && int'(ln) == a_ln[0] && int'(px) == a_px[0]) begin
          m_ph = 1; m_lvl = 1 - a_pol;
        end else if (m_ph == 1 && int'(ln) == a_ln[1] && int'(px) == a_px[1] &&
                     (a_ln[1] * 8192 + a_px[1] > a_ln[0] * 8192 + a_px[0])) begin
          m_ph = 2; m_lvl = a_pol;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: s_pol = int'(wr_data[0]);
          3'd1, 3'd2: begin
            s_ln[wr_addr - 3'd1] = int'(wr_data[11:0]);
            s_px[wr_addr - 3'd1] = int'(wr_data[25:13]);
          end
          3'd3: begin s_sel = int'(wr_data[2:0]); s_en = int'(wr_data[3]); end
          3'd4: s_mode = int'(wr_data[0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(pulse_o == m_lvl[0], cur_req, "pulse_o", int'(pulse_o), m_lvl);
      chk(sync_oe_o == (a_mode == 0), "R5", "sync_oe_o", int'(sync_oe_o), int'(a_mode == 0));
      if (a_mode == 0) begin
        chk(sync_o == m_lvl[0], "R5", "sync_o", int'(sync_o), m_lvl);
        chk(sync_ext_o == 1'b0, "R5", "sync_ext_o", int'(sync_ext_o), 0);
      end else
        chk(sync_ext_o == sync_i, "R5", "sync_ext_o", int'(sync_ext_o), int'(sync_i));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [25:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2 layout: line [11:0], pixel [25:13], bit 12 deliberately set as junk
  function automatic logic [25:0] pos(input int l, input int p);
    return {13'(p), 1'b1, 12'(l)};
  endfunction

  task automatic run_fields(input int n);
    repeat (n * FIELD_CYC) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_i = 1'b0;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk(pulse_o == 1'b0, "R6", "pulse_o in reset", int'(pulse_o), 0);
    chk(sync_oe_o == 1'b1, "R6", "sync_oe_o in reset", int'(sync_oe_o), 1);
    rst_n = 1'b1;
    cur_req = "R6";
    run_fields(1);

    // R2 / R3 / R7 / R11: window from (1,3) to (3,5) in field 1
    cur_req = "R3";
    wr(ADDR_ON, pos(1, 3));
    wr(ADDR_OFF, pos(3, 5));
    wr(ADDR_FSEL, 26'h9);
    run_fields(4);
    cur_req = "R7";
    run_fields(2);

    // R1: inverted idle level
    cur_req = "R1";
    wr(ADDR_IDLE, 26'd1);
    run_fields(3);

    // R3: other field, then a field count never reached
    cur_req = "R3";
    wr(ADDR_FSEL, 26'hA);
    run_fields(3);
    wr(ADDR_FSEL, 26'hF);
    run_fields(3);

    // R4: enable cleared
    cur_req = "R4";
    wr(ADDR_FSEL, 26'h1);
    run_fields(3);

    // R8: second point equal to, then earlier than, the first
    cur_req = "R8";
    wr(ADDR_IDLE, 26'd0);
    wr(ADDR_FSEL, 26'h9);
    wr(ADDR_OFF, pos(1, 3));
    run_fields(3);
    wr(ADDR_OFF, pos(0, 8));
    run_fields(3);

    // R9: second point beyond the field, restore at field start
    cur_req = "R9";
    wr(ADDR_OFF, pos(9, 2));
    run_fields(4);

    // R10: mid-field writes only land at the boundary
    cur_req = "R10";
    repeat (20) @(negedge clk);
    wr(ADDR_IDLE, 26'd1);
    wr(ADDR_ON, pos(2, 7));
    wr(ADDR_OFF, pos(4, 1));
    run_fields(4);

    // R11: a point on the field-start pixel is never acted upon
    cur_req = "R11";
    wr(ADDR_ON, pos(0, 0));
    run_fields(4);
    wr(ADDR_ON, pos(0, 1));
    wr(ADDR_OFF, pos(5, 9));
    run_fields(4);

    // R5: pad released as input
    cur_req = "R5";
    wr(ADDR_PAD, 26'd1);
    for (int i = 0; i < 2 * FIELD_CYC; i++) begin
      @(negedge clk);
      sync_i = ~sync_i;
    end
    wr(ADDR_PAD, 26'd0);
    run_fields(2);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule